// File: doc/BRIEF.md
# Two-Bank Misaligned Vector Line Port

This block is the data side of a cache built for unit-stride vector traffic. Every access hits, so there is no tag lookup, miss handling or translation. The storage is organised as lines of `LINE_WORDS` words. Lines with an even number live in one bank and lines with an odd number live in the other. Because of this split, any two neighbouring lines can be read or written in the same cycle.

One request moves a run of up to one line of words. The run may start at any word address. On a load, the block reads the two lines that the run touches. It orders the two lines so the lower-numbered one comes first, moves the run down so that the start word becomes element 0, and clears every element past the requested length. The whole vector is returned one cycle after the request.

A store runs the same steps in reverse. The incoming vector is first moved up and masked into a two-line window. The window is then split between the banks, and the words are written with per-word enables one cycle later. A store therefore completes in two cycles and blocks new requests during its second cycle. Addresses wrap from the last line back to line 0.

Top module: `vline_access`

## Requirements
- R1: Line L is held in bank L mod 2. A load whose run starts in an even line and crosses into the following odd line returns the words of both lines in a single access.
- R2: An accepted load (req_valid=1, req_ready=1, req_store=0) raises rd_valid in the next cycle. Element j of rd_data (bits j*64 to j*64+63) then holds the word at address req_addr+j, for j below the length. rd_valid is low in every cycle that does not follow an accepted load.
- R3: In rd_data, every element at or beyond the effective length is zero.
- R4: A load whose run starts in an odd line and crosses into the next line returns the elements in address order. This includes the run that starts in the last line and continues in line 0.
- R5: An accepted store writes element j of req_wdata (bits j*64 to j*64+63) to word address req_addr+j, for every j below the effective length. Addresses wrap modulo the storage size.
- R6: A store changes no word outside the run [req_addr, req_addr+length). When the run fits inside one line, the other bank receives no write enable at all.
- R7: After an accepted store, req_ready is low for exactly one cycle and wr_done is high in the second cycle after acceptance.
- R8: A request presented while req_ready is low is dropped. It produces no rd_valid, no wr_done and no write.
- R9: A length of 0 completes like any other request: a load gives rd_valid with all-zero data, and a store gives wr_done. Neither changes any stored word.
- R10: After reset, rd_valid and wr_done are low and req_ready is high.
- R11: A req_len above LINE_WORDS is treated as exactly LINE_WORDS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | 8 | Start word address |
| req_len | input | 5 | Number of words (values above 16 are clamped to 16) |
| req_wdata | input | 1024 | Store vector; element j at bits j*64 and up |
| req_ready | output | 1 | High when a request can be accepted |
| rd_valid | output | 1 | Load result valid |
| rd_data | output | 1024 | Aligned, masked load vector |
| wr_done | output | 1 | Store completed |

## Verification
The bench sweeps every start offset within a line, once with the first line even and once with it odd. A missing or inverted bank swap then returns the second line's words in front of the first. The wrap from the last line to line 0 is exercised, because a carry mistake there would fetch the wrong bank row. Short stores are followed by reads of the neighbouring lines in both banks, so an enable that spills into the untouched bank or past the run shows up as corrupted neighbours. Zero-length, over-long and busy-cycle requests are also issued: a design that wrote on length 0, failed to clamp the length, or accepted a request during a store's second cycle would produce data or handshake timing that differs from the reference model.

// File: rtl/vla_pkg.sv
package vla_pkg;
  typedef enum logic [0:0] {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } vla_op_e;
endpackage

// File: rtl/vla_bank.sv
// One bank of line storage: synchronous read, per-word write enables.
module vla_bank #(
  parameter int WORD_W = 64,
  parameter int LINE_WORDS = 16,
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LINE_BITS = WORD_W * LINE_WORDS
)(
  input  logic                  clk,
  input  logic                  rd_en,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [LINE_BITS-1:0]  rd_line,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [LINE_WORDS-1:0] wr_we,
  input  logic [LINE_BITS-1:0]  wr_line
);
  logic [LINE_BITS-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rd_en) rd_line <= mem[rd_idx];
    for (int w = 0; w < LINE_WORDS; w++) begin
      if (wr_we[w]) mem[wr_idx][w*WORD_W +: WORD_W] <= wr_line[w*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/vla_load_align.sv
// Load path: order the two bank lines, move the run down to element 0, clear the tail.
module vla_load_align #(
  parameter int WORD_W = 64,
  parameter int LINE_WORDS = 16,
  localparam int OFF_W = $clog2(LINE_WORDS),
  localparam int LEN_W = $clog2(LINE_WORDS + 1),
  localparam int VEC_W = WORD_W * LINE_WORDS
)(
  input  logic [VEC_W-1:0] line_even,
  input  logic [VEC_W-1:0] line_odd,
  input  logic             swap,
  input  logic [OFF_W-1:0] off,
  input  logic [LEN_W-1:0] len,
  output logic [VEC_W-1:0] vec
);
  logic [2*VEC_W-1:0] pair;

  always_comb begin
    pair = swap ? {line_even, line_odd} : {line_odd, line_even};
    vec = '0;
    for (int j = 0; j < LINE_WORDS; j++) begin
      if (j < int'(len)) vec[j*WORD_W +: WORD_W] = pair[(int'(off) + j)*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/vla_store_align.sv
// Store path: move the vector up into a two-line window with enables, then split by bank.
module vla_store_align #(
  parameter int WORD_W = 64,
  parameter int LINE_WORDS = 16,
  localparam int OFF_W = $clog2(LINE_WORDS),
  localparam int LEN_W = $clog2(LINE_WORDS + 1),
  localparam int VEC_W = WORD_W * LINE_WORDS
)(
  input  logic [VEC_W-1:0]      wdata,
  input  logic [OFF_W-1:0]      off,
  input  logic [LEN_W-1:0]      len,
  input  logic                  odd_first,
  output logic [VEC_W-1:0]      even_line,
  output logic [VEC_W-1:0]      odd_line,
  output logic [LINE_WORDS-1:0] even_we,
  output logic [LINE_WORDS-1:0] odd_we
);
  logic [2*VEC_W-1:0]      win;
  logic [2*LINE_WORDS-1:0] win_we;

  always_comb begin
    win = '0;
    win_we = '0;
    for (int p = 0; p < 2*LINE_WORDS; p++) begin
      if (p >= int'(off) && p < int'(off) + int'(len)) begin
        win[p*WORD_W +: WORD_W] = wdata[(p - int'(off))*WORD_W +: WORD_W];
        win_we[p] = 1'b1;
      end
    end
    if (odd_first) begin
      odd_line  = win[VEC_W-1:0];
      odd_we    = win_we[LINE_WORDS-1:0];
      even_line = win[2*VEC_W-1:VEC_W];
      even_we   = win_we[2*LINE_WORDS-1:LINE_WORDS];
    end else begin
      even_line = win[VEC_W-1:0];
      even_we   = win_we[LINE_WORDS-1:0];
      odd_line  = win[2*VEC_W-1:VEC_W];
      odd_we    = win_we[2*LINE_WORDS-1:LINE_WORDS];
    end
  end
endmodule

// File: rtl/vline_access.sv
module vline_access
  import vla_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int LINE_WORDS = 16,
  parameter int NUM_LINES = 16,
  localparam int OFF_W = $clog2(LINE_WORDS),
  localparam int LNUM_W = $clog2(NUM_LINES),
  localparam int ADDR_W = OFF_W + LNUM_W,
  localparam int LEN_W = $clog2(LINE_WORDS + 1),
  localparam int VEC_W = WORD_W * LINE_WORDS
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [VEC_W-1:0]  req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [VEC_W-1:0]  rd_data,
  output logic              wr_done
);
  localparam int HALF   = NUM_LINES / 2;
  localparam int BIDX_W = (HALF > 1) ? $clog2(HALF) : 1;

  vla_op_e           op_c;
  logic              accept;
  logic [LEN_W-1:0]  len_c;
  logic [OFF_W-1:0]  off_c;
  logic [LNUM_W-1:0] line_c, next_c;
  logic              odd_first_c, span_c;
  logic [BIDX_W-1:0] even_idx_c, odd_idx_c;

  // request decode
  assign op_c        = req_store ? OP_STORE : OP_LOAD;
  assign accept      = req_valid && req_ready;
  assign len_c       = (req_len > LEN_W'(LINE_WORDS)) ? LEN_W'(LINE_WORDS) : req_len;
  assign off_c       = req_addr[OFF_W-1:0];
  assign line_c      = req_addr[ADDR_W-1:OFF_W];
  assign next_c      = line_c + 1'b1;
  assign odd_first_c = line_c[0];
  assign even_idx_c  = odd_first_c ? next_c[LNUM_W-1:1] : line_c[LNUM_W-1:1];
  assign odd_idx_c   = line_c[LNUM_W-1:1];
  assign span_c      = ((LEN_W+1)'(off_c) + (LEN_W+1)'(len_c)) > (LEN_W+1)'(LINE_WORDS);

  // load stage registers
  logic             ld_en;
  logic [OFF_W-1:0] ld_off;
  logic [LEN_W-1:0] ld_len;
  logic             ld_swap;

  assign ld_en = accept && (op_c == OP_LOAD) && (len_c != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      ld_off   <= '0;
      ld_len   <= '0;
      ld_swap  <= 1'b0;
    end else begin
      rd_valid <= accept && (op_c == OP_LOAD);
      if (accept && (op_c == OP_LOAD)) begin
        ld_off  <= off_c;
        ld_len  <= len_c;
        ld_swap <= odd_first_c;
      end
    end
  end

  // store stage: shift/mask/swap in cycle one, bank write in cycle two
  logic [VEC_W-1:0]      sa_even_line, sa_odd_line;
  logic [LINE_WORDS-1:0] sa_even_we, sa_odd_we;

  vla_store_align #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_store_align (
    .wdata     (req_wdata),
    .off       (off_c),
    .len       (len_c),
    .odd_first (odd_first_c),
    .even_line (sa_even_line),
    .odd_line  (sa_odd_line),
    .even_we   (sa_even_we),
    .odd_we    (sa_odd_we)
  );

  logic                  st_busy, st_span, st_odd_first;
  logic [LEN_W-1:0]      st_len;
  logic [VEC_W-1:0]      st_even_line, st_odd_line;
  logic [LINE_WORDS-1:0] st_even_we, st_odd_we;
  logic [BIDX_W-1:0]     st_even_idx, st_odd_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_busy      <= 1'b0;
      wr_done      <= 1'b0;
      st_even_we   <= '0;
      st_odd_we    <= '0;
      st_span      <= 1'b0;
      st_odd_first <= 1'b0;
      st_len       <= '0;
    end else begin
      st_busy <= accept && (op_c == OP_STORE);
      wr_done <= st_busy;
      if (accept && (op_c == OP_STORE)) begin
        st_even_we   <= sa_even_we;
        st_odd_we    <= sa_odd_we;
        st_span      <= span_c;
        st_odd_first <= odd_first_c;
        st_len       <= len_c;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept && (op_c == OP_STORE)) begin
      st_even_line <= sa_even_line;
      st_odd_line  <= sa_odd_line;
      st_even_idx  <= even_idx_c;
      st_odd_idx   <= odd_idx_c;
    end
  end

  assign req_ready = !st_busy;

  // the two banks
  logic [VEC_W-1:0]      bk_rd_line [2];
  logic [VEC_W-1:0]      bk_wr_line [2];
  logic [LINE_WORDS-1:0] bk_we      [2];
  logic [BIDX_W-1:0]     bk_rd_idx  [2];
  logic [BIDX_W-1:0]     bk_wr_idx  [2];

  assign bk_rd_idx[0]  = even_idx_c;
  assign bk_rd_idx[1]  = odd_idx_c;
  assign bk_wr_idx[0]  = st_even_idx;
  assign bk_wr_idx[1]  = st_odd_idx;
  assign bk_wr_line[0] = st_even_line;
  assign bk_wr_line[1] = st_odd_line;
  assign bk_we[0]      = st_busy ? st_even_we : '0;
  assign bk_we[1]      = st_busy ? st_odd_we  : '0;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    vla_bank #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .DEPTH(HALF)) u_bank (
      .clk     (clk),
      .rd_en   (ld_en),
      .rd_idx  (bk_rd_idx[b]),
      .rd_line (bk_rd_line[b]),
      .wr_idx  (bk_wr_idx[b]),
      .wr_we   (bk_we[b]),
      .wr_line (bk_wr_line[b])
    );
  end

  vla_load_align #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_load_align (
    .line_even (bk_rd_line[0]),
    .line_odd  (bk_rd_line[1]),
    .swap      (ld_swap),
    .off       (ld_off),
    .len       (ld_len),
    .vec       (rd_data)
  );

  // checks
  function automatic logic tail_clear(input logic [VEC_W-1:0] v, input logic [LEN_W-1:0] n);
    for (int j = 0; j < LINE_WORDS; j++) begin
      if (j >= int'(n) && v[j*WORD_W +: WORD_W] != '0) return 1'b0;
    end
    return 1'b1;
  endfunction

  assert_load_valid_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_store) |=> rd_valid);

  assert_no_stray_valid_R2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(req_valid && req_ready && !req_store));

  assert_tail_zero_R3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> tail_clear(rd_data, ld_len));

  assert_store_timing_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_store) |=> (!req_ready ##1 wr_done));

  assert_enable_count_R5: assert property (@(posedge clk) disable iff (rst)
    st_busy |-> ($countones({bk_we[1], bk_we[0]}) == int'(st_len)));

  assert_quiet_bank_R6: assert property (@(posedge clk) disable iff (rst)
    (st_busy && !st_span) |-> (st_odd_first ? (bk_we[0] == '0) : (bk_we[1] == '0)));

  assert_idle_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    !st_busy |-> (bk_we[0] == '0 && bk_we[1] == '0));

  assert_len_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_store && req_len == '0) |=> (bk_we[0] == '0 && bk_we[1] == '0));
endmodule

// File: tb/vline_access_bench.sv
module vline_access_bench;
  localparam int WW = 64;
  localparam int LW = 16;
  localparam int NW = 256;
  localparam int VW = WW * LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_store = 1'b0;
  logic [7:0]    req_addr = '0;
  logic [4:0]    req_len = '0;
  logic [VW-1:0] req_wdata = '0;
  logic          req_ready, rd_valid, wr_done;
  logic [VW-1:0] rd_data;

  always #4 clk = ~clk;

  vline_access u_vline_access (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data), .wr_done(wr_done)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    chk_on = 1'b0;
  string cur_tag = "R10";

  // behavioural reference model
  logic [WW-1:0] ref_mem [NW];
  logic          exp_ready = 1'b1;
  logic          exp_rdv = 1'b0;
  logic          exp_wd_pipe = 1'b0;
  logic          exp_wd = 1'b0;
  logic [VW-1:0] exp_data = '0;

  always @(posedge clk) begin
    if (rst) begin
      exp_ready   <= 1'b1;
      exp_rdv     <= 1'b0;
      exp_wd_pipe <= 1'b0;
      exp_wd      <= 1'b0;
    end else begin
      int n;
      logic [VW-1:0] tmp;
      logic acc;
      acc = req_valid && exp_ready;
      n = (int'(req_len) > LW) ? LW : int'(req_len);
      tmp = '0;
      if (acc && req_store) begin
        for (int j = 0; j < n; j++) ref_mem[(int'(req_addr) + j) % NW] = req_wdata[j*WW +: WW];
      end else if (acc) begin
        for (int j = 0; j < n; j++) tmp[j*WW +: WW] = ref_mem[(int'(req_addr) + j) % NW];
        exp_data <= tmp;
      end
      exp_rdv     <= acc && !req_store;
      exp_wd_pipe <= acc && req_store;
      exp_wd      <= exp_wd_pipe;
      exp_ready   <= !(acc && req_store);
    end
  end

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !rst) begin
      check_bit("R7/R8 req_ready", req_ready, exp_ready);
      check_bit("R2 rd_valid", rd_valid, exp_rdv);
      check_bit("R7 wr_done", wr_done, exp_wd);
      if (exp_rdv) begin
        n_chk++;
        if (rd_data !== exp_data) begin
          n_bad++;
          for (int j = 0; j < LW; j++) begin
            if (rd_data[j*WW +: WW] !== exp_data[j*WW +: WW]) begin
              $display("FAIL %s rd_data element %0d: actual=%h expected=%h at %0t",
                       cur_tag, j, rd_data[j*WW +: WW], exp_data[j*WW +: WW], $time);
              break;
            end
          end
        end
      end
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [VW-1:0] pat(input int a, input int s);
    logic [VW-1:0] v;
    for (int j = 0; j < LW; j++) v[j*WW +: WW] = {16'(s), 16'(a), 16'(j), 16'(s * 97 + a * 13 + j)};
    return v;
  endfunction

  task automatic put(input bit st, input int a, input int n, input logic [VW-1:0] d);
    req_valid = 1'b1;
    req_store = st;
    req_addr  = 8'(a % NW);
    req_len   = 5'(n);
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ld(input int a, input int n);
    put(1'b0, a, n, '0);
  endtask

  task automatic st(input int a, input int n, input int s);
    put(1'b1, a, n, pat(a, s));
    @(negedge clk);
  endtask

  int unsigned lcg = 32'h1234_5678;
  function automatic int unsigned rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg >> 8;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: state after reset
    check_bit("R10 req_ready", req_ready, 1'b1);
    check_bit("R10 rd_valid", rd_valid, 1'b0);
    check_bit("R10 wr_done", wr_done, 1'b0);
    chk_on = 1'b1;

    cur_tag = "R5";   // fill every line with full aligned stores
    for (int l = 0; l < 16; l++) st(l*LW, LW, 1 + l);
    cur_tag = "R2";   // aligned full-line loads
    for (int l = 0; l < 16; l++) ld(l*LW, LW);
    cur_tag = "R1";   // even line first, crossing into the odd bank
    for (int o = 1; o < LW; o++) ld(2*LW + o, LW);
    cur_tag = "R4";   // odd line first needs the swap, and wrap to line 0
    for (int o = 1; o < LW; o++) ld(3*LW + o, LW);
    ld(15*LW + 5, LW);
    ld(255, 2);
    cur_tag = "R3";   // short loads, tail must be zero
    for (int n = 1; n < LW; n++) ld(5*LW + (n % 7), n);
    ld(7*LW + 12, 9);
    cur_tag = "R6";   // stores inside one line and across lines, neighbours intact
    st(4*LW + 3, 5, 40);
    ld(4*LW, LW); ld(5*LW, LW); ld(3*LW, LW);
    st(6*LW + 10, 12, 41);
    ld(6*LW, LW); ld(7*LW, LW); ld(8*LW, LW);
    st(9*LW + 9, 16, 42);
    ld(9*LW, LW); ld(10*LW, LW); ld(11*LW, LW);
    st(15*LW + 14, 6, 43);
    ld(15*LW, LW); ld(0, LW); ld(LW, LW);
    cur_tag = "R9";   // zero length
    ld(9*LW + 4, 0);
    st(9*LW + 4, 0, 44);
    ld(9*LW, LW); ld(10*LW, LW);
    cur_tag = "R11";  // over-long length clamped
    ld(11*LW + 7, 31);
    st(12*LW + 9, 20, 45);
    ld(12*LW, LW); ld(13*LW, LW);
    cur_tag = "R8";   // request in the store's busy cycle is dropped
    put(1'b1, 13*LW + 2, 4, pat(0, 46));
    put(1'b1, 13*LW + 8, 4, pat(0, 47));
    put(1'b0, 13*LW, LW, '0);
    put(1'b0, 13*LW, LW, '0);
    put(1'b1, 14*LW + 1, 3, pat(0, 48));
    put(1'b0, 14*LW, LW, '0);
    @(negedge clk);
    ld(14*LW, LW);
    cur_tag = "R2/R5 mixed";
    for (int i = 0; i < 400; i++) begin
      int a, n;
      a = int'(rnd() % NW);
      n = int'(rnd() % 18);
      if (rnd() % 3 == 0) st(a, n, 100 + i);
      else ld(a, n);
    end
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule